// File: doc/BRIEF.md
# Display List Launch and Bank Controller

This block decides when a display-list coprocessor begins fetching instructions, from which address, and in which memory bank. The host CPU writes a control register (a port bank field and an enable flag) and a primary 16-bit start address held as two bytes. It can also force an immediate launch through a primary go register. The running display list has its own small register set: a secondary 16-bit start address and a secondary go register. A write to the secondary go register jumps to the secondary address, and it can also switch the execution bank.

The execution bank is kept apart from the CPU port bank. It follows the control register only when that register is written with the enable flag clear. When a list reports its end, the controller reloads the primary start address in whatever execution bank is in force at that moment. With the enable flag set, each frame-start pulse relaunches the list from the primary address.

Each launch produces a one-cycle `pc_load` pulse. The pulse carries the chosen address on `pc_addr` and the bank on `exec_bank`. The coprocessor uses these to reload its program counter.

Top module: `dl_launch_ctrl`

## Requirements
- R1: After reset, `run`, `pc_load`, `pc_addr`, `exec_bank` and `port_bank` are all zero.
- R2: A host write with `host_sel`=0 stores bits [2:0] into `port_bank` and bit 3 as the enable flag. With the enable flag set, a `frame_start` pulse causes, one cycle later, a load of the primary address and `run`=1. With the flag clear, `frame_start` causes nothing.
- R3: A host write with `host_sel`=0 and bit 3 = 0 forces `run` to 0 in the next cycle, with no load.
- R4: A host write with `host_sel`=3 causes, in the next cycle, a load of the primary address (low byte at `host_sel`=1, high byte at `host_sel`=2) and `run`=1, whatever the enable flag.
- R5: A host write with `host_sel`=0 and bit 3 = 0 copies bits [2:0] into `exec_bank`. With bit 3 = 1, `exec_bank` is left unchanged.
- R6: While `run` is 0, every coprocessor write is ignored: it causes no load and changes neither the secondary address nor the execution bank.
- R7: While running, a coprocessor write with `cop_sel`=2 causes, in the next cycle, a load of the secondary address (low byte at `cop_sel`=0, high byte at `cop_sel`=1).
- R8: For that secondary go write, if bit 3 of the value is 1, bits [2:0] become `exec_bank`, and the accompanying load carries them. If bit 3 is 0, the bank is kept.
- R9: `list_end` while running reloads the primary address with the current `exec_bank`. `list_end` while stopped is ignored.
- R10: When triggers coincide, the priority is: stop write, then primary go, then secondary go, then list end, then frame start. A losing secondary go does not change the bank.
- R11: Each launch gives exactly one `pc_load` cycle. `pc_addr` holds its value between loads, and `pc_load` implies `run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 2 | Host register: 0 control, 1 primary low, 2 primary high, 3 primary go |
| host_wdata | input | 8 | Host write data |
| cop_wr | input | 1 | Coprocessor register write strobe |
| cop_sel | input | 2 | Coprocessor register: 0 secondary low, 1 secondary high, 2 secondary go |
| cop_wdata | input | 8 | Coprocessor write data |
| frame_start | input | 1 | One-cycle frame-start pulse |
| list_end | input | 1 | End-of-list indication from the coprocessor |
| run | output | 1 | Display list executing |
| pc_load | output | 1 | One-cycle program-counter load pulse |
| pc_addr | output | 16 | Address to load |
| exec_bank | output | 3 | Bank in which the list executes |
| port_bank | output | 3 | Bank for CPU port accesses |

## Verification
The hardest situation to reach from the ports is several triggers landing in the same cycle. One case is a primary go arriving together with a frame start, a list end and a bank-switching secondary go. Another is a stop write meeting a secondary go. The stimulus first brings the block into the running state, then raises all of these inputs on one negative edge. A scoreboard then confirms that only the winning load appears, carrying the bank it should.

A second hard case is proving that coprocessor writes have no effect while stopped. The bench writes a new secondary low byte and a bank-changing go while stopped. It then restarts and issues a secondary go, and the scoreboard expects the old address and bank.

// File: rtl/dl_launch_pkg.sv
package dl_launch_pkg;
  typedef enum logic [1:0] {
    HREG_CTRL    = 2'd0,
    HREG_PRIM_LO = 2'd1,
    HREG_PRIM_HI = 2'd2,
    HREG_PRIM_GO = 2'd3
  } host_reg_e;

  typedef enum logic [1:0] {
    CREG_SEC_LO = 2'd0,
    CREG_SEC_HI = 2'd1,
    CREG_SEC_GO = 2'd2,
    CREG_NONE   = 2'd3
  } cop_reg_e;

  typedef enum logic [2:0] {
    SRC_NONE    = 3'd0,
    SRC_STOP    = 3'd1,
    SRC_PRIM    = 3'd2,
    SRC_SEC     = 3'd3,
    SRC_RESTART = 3'd4,
    SRC_FRAME   = 3'd5
  } launch_src_e;
endpackage

// File: rtl/dl_rst_sync.sv
module dl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/dl_addr_pair.sv
module dl_addr_pair #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr
);
  logic [1:0] lane_we;
  assign lane_we = {hi_we, lo_we};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [DATA_W-1:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          byte_q <= '0;
      else if (lane_we[g]) byte_q <= wdata;
    end
    assign addr[g*DATA_W +: DATA_W] = byte_q;
  end
endmodule

// File: rtl/dl_ctrl_reg.sv
module dl_ctrl_reg #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 3,
  localparam int EN_BIT = BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              enable,
  output logic [BANK_W-1:0] port_bank
);
  logic              en_q, en_d;
  logic [BANK_W-1:0] bank_q, bank_d;

  always_comb begin
    en_d   = en_q;
    bank_d = bank_q;
    if (we) begin
      en_d   = wdata[EN_BIT];
      bank_d = wdata[BANK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      bank_q <= '0;
    end else if (we) begin
      en_q   <= en_d;
      bank_q <= bank_d;
    end
  end

  assign enable    = en_q;
  assign port_bank = bank_q;
endmodule

// File: rtl/dl_seq.sv
module dl_seq
  import dl_launch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              frame_start,
  input  logic              list_end,
  input  logic              stop_req,
  input  logic              copy_req,
  input  logic [BANK_W-1:0] copy_val,
  input  logic              prim_go,
  input  logic              sec_go,
  input  logic              sec_bank_chg,
  input  logic [BANK_W-1:0] sec_bank_val,
  input  logic [ADDR_W-1:0] prim_addr,
  input  logic [ADDR_W-1:0] sec_addr,
  output logic              run,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_addr,
  output logic [BANK_W-1:0] exec_bank
);
  launch_src_e       src;
  logic              run_q, run_d;
  logic              load_q, load_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BANK_W-1:0] bank_q, bank_d;

  always_comb begin
    src = SRC_NONE;
    if (stop_req)                src = SRC_STOP;
    else if (prim_go)            src = SRC_PRIM;
    else if (sec_go)             src = SRC_SEC;
    else if (run_q && list_end)  src = SRC_RESTART;
    else if (enable && frame_start) src = SRC_FRAME;
  end

  always_comb begin
    run_d  = run_q;
    load_d = 1'b0;
    addr_d = addr_q;
    bank_d = bank_q;
    if (copy_req) bank_d = copy_val;
    unique case (src)
      SRC_STOP: run_d = 1'b0;
      SRC_PRIM, SRC_RESTART, SRC_FRAME: begin
        load_d = 1'b1;
        run_d  = 1'b1;
        addr_d = prim_addr;
      end
      SRC_SEC: begin
        load_d = 1'b1;
        run_d  = 1'b1;
        addr_d = sec_addr;
        if (sec_bank_chg) bank_d = sec_bank_val;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      load_q <= 1'b0;
      addr_q <= '0;
      bank_q <= '0;
    end else begin
      run_q  <= run_d;
      load_q <= load_d;
      bank_q <= bank_d;
      if (load_d) addr_q <= addr_d;
    end
  end

  assign run       = run_q;
  assign pc_load   = load_q;
  assign pc_addr   = addr_q;
  assign exec_bank = bank_q;
endmodule

// File: rtl/dl_launch_ctrl.sv
module dl_launch_ctrl
  import dl_launch_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BANK_W = 3,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [1:0]        host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              cop_wr,
  input  logic [1:0]        cop_sel,
  input  logic [DATA_W-1:0] cop_wdata,
  input  logic              frame_start,
  input  logic              list_end,
  output logic              run,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_addr,
  output logic [BANK_W-1:0] exec_bank,
  output logic [BANK_W-1:0] port_bank
);
  localparam int FLAG_BIT = BANK_W;

  host_reg_e         hsel;
  cop_reg_e          csel;
  logic              rst_q_n;
  logic              ctrl_we, stop_req, prim_go, cop_ok, sec_go;
  logic              enable;
  logic [ADDR_W-1:0] prim_addr, sec_addr;

  assign hsel     = host_reg_e'(host_sel);
  assign csel     = cop_reg_e'(cop_sel);
  assign ctrl_we  = host_wr && (hsel == HREG_CTRL);
  assign stop_req = ctrl_we && !host_wdata[FLAG_BIT];
  assign prim_go  = host_wr && (hsel == HREG_PRIM_GO);
  assign cop_ok   = cop_wr && run;
  assign sec_go   = cop_ok && (csel == CREG_SEC_GO);

  dl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  dl_ctrl_reg #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_ctrl (
    .clk(clk), .rst_n(rst_q_n), .we(ctrl_we), .wdata(host_wdata),
    .enable(enable), .port_bank(port_bank)
  );

  dl_addr_pair #(.DATA_W(DATA_W)) u_prim (
    .clk(clk), .rst_n(rst_q_n),
    .lo_we(host_wr && (hsel == HREG_PRIM_LO)),
    .hi_we(host_wr && (hsel == HREG_PRIM_HI)),
    .wdata(host_wdata), .addr(prim_addr)
  );

  dl_addr_pair #(.DATA_W(DATA_W)) u_sec (
    .clk(clk), .rst_n(rst_q_n),
    .lo_we(cop_ok && (csel == CREG_SEC_LO)),
    .hi_we(cop_ok && (csel == CREG_SEC_HI)),
    .wdata(cop_wdata), .addr(sec_addr)
  );

  dl_seq #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_seq (
    .clk(clk), .rst_n(rst_q_n), .enable(enable),
    .frame_start(frame_start), .list_end(list_end),
    .stop_req(stop_req), .copy_req(stop_req),
    .copy_val(host_wdata[BANK_W-1:0]),
    .prim_go(prim_go), .sec_go(sec_go),
    .sec_bank_chg(cop_wdata[FLAG_BIT]),
    .sec_bank_val(cop_wdata[BANK_W-1:0]),
    .prim_addr(prim_addr), .sec_addr(sec_addr),
    .run(run), .pc_load(pc_load), .pc_addr(pc_addr), .exec_bank(exec_bank)
  );
endmodule

// File: rtl/dl_launch_chk.sv
module dl_launch_chk #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 3,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [1:0]        host_sel,
  input logic [DATA_W-1:0] host_wdata,
  input logic              cop_wr,
  input logic [1:0]        cop_sel,
  input logic [DATA_W-1:0] cop_wdata,
  input logic              frame_start,
  input logic              run,
  input logic              pc_load,
  input logic [ADDR_W-1:0] pc_addr,
  input logic [BANK_W-1:0] exec_bank
);
  logic ctrl_clr, ctrl_set, cop_go;
  assign ctrl_clr = host_wr && host_sel == 2'd0 && !host_wdata[BANK_W];
  assign ctrl_set = host_wr && host_sel == 2'd0 && host_wdata[BANK_W];
  assign cop_go   = cop_wr && cop_sel == 2'd2;

  a_r3_stop_at_once: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_clr |=> (!run && !pc_load));

  a_r4_go_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == 2'd3) |=> (pc_load && run));

  a_r5_bank_copy: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_clr |=> (exec_bank == $past(host_wdata[BANK_W-1:0])));

  a_r5_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_set && !cop_go) |=> $stable(exec_bank));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !host_wr && !frame_start) |=> (!run && !pc_load && $stable(exec_bank)));

  a_r11_load_runs: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> run);

  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_load |-> $stable(pc_addr));
endmodule

bind dl_launch_ctrl dl_launch_chk #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .host_wr(host_wr), .host_sel(host_sel),
  .host_wdata(host_wdata), .cop_wr(cop_wr), .cop_sel(cop_sel),
  .cop_wdata(cop_wdata), .frame_start(frame_start), .run(run),
  .pc_load(pc_load), .pc_addr(pc_addr), .exec_bank(exec_bank)
);

// File: tb/tb_dl_launch_ctrl.sv
module tb_dl_launch_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, cop_wr, frame_start, list_end;
  logic [1:0]  host_sel, cop_sel;
  logic [7:0]  host_wdata, cop_wdata;
  logic        run, pc_load;
  logic [15:0] pc_addr;
  logic [2:0]  exec_bank, port_bank;

  typedef struct {
    logic [15:0] addr;
    logic [2:0]  bank;
    string       tag;
  } exp_t;

  exp_t expq[$];
  exp_t mon_e;
  int   nchk = 0;
  int   nfail = 0;
  bit   mon_on = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  dl_launch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .cop_wr(cop_wr), .cop_sel(cop_sel),
    .cop_wdata(cop_wdata), .frame_start(frame_start), .list_end(list_end),
    .run(run), .pc_load(pc_load), .pc_addr(pc_addr),
    .exec_bank(exec_bank), .port_bank(port_bank)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Monitor: pops one expected load per pc_load cycle
  always @(negedge clk) begin
    if (mon_on && pc_load) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R11 unexpected load", {13'd0, exec_bank, pc_addr}, 32'd0);
      end else begin
        mon_e = expq.pop_front();
        chk(pc_addr == mon_e.addr, mon_e.tag, {16'd0, pc_addr}, {16'd0, mon_e.addr});
        chk(exec_bank == mon_e.bank, mon_e.tag, {29'd0, exec_bank}, {29'd0, mon_e.bank});
      end
    end
  end

  task automatic expect_load(input logic [15:0] a, input logic [2:0] b, input string tag);
    exp_t e;
    e.addr = a; e.bank = b; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic hwr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic cwr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cop_wr = 1'b1; cop_sel = s; cop_wdata = d;
    @(negedge clk);
    cop_wr = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); list_end = 1'b1;
    @(negedge clk); list_end = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_wr = 0; cop_wr = 0; frame_start = 0; list_end = 0;
    host_sel = 0; cop_sel = 0; host_wdata = 0; cop_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1;
    // R1 reset state
    chk(!run && !pc_load, "R1 run/load", {30'd0, run, pc_load}, 32'd0);
    chk(pc_addr == 0 && exec_bank == 0 && port_bank == 0, "R1 regs",
        {10'd0, exec_bank, port_bank, pc_addr}, 32'd0);

    // primary address 1234, control bank 5 enable off
    hwr(2'd1, 8'h34);
    hwr(2'd2, 8'h12);
    hwr(2'd0, 8'h05);
    chk(exec_bank == 3'd5, "R5 copy bank", {29'd0, exec_bank}, 32'd5);
    chk(port_bank == 3'd5, "R2 port bank", {29'd0, port_bank}, 32'd5);

    // R2 frame with enable off does nothing
    pulse_frame();
    chk(!run, "R2 no start when disabled", {31'd0, run}, 32'd0);

    // enable on, bank 2: exec bank stays 5
    hwr(2'd0, 8'h0A);
    chk(exec_bank == 3'd5, "R5 bank kept with enable", {29'd0, exec_bank}, 32'd5);
    chk(port_bank == 3'd2, "R2 port bank", {29'd0, port_bank}, 32'd2);
    chk(!run, "R2 waits for frame", {31'd0, run}, 32'd0);

    expect_load(16'h1234, 3'd5, "R2 frame launch");
    pulse_frame();
    chk(run, "R2 running after frame", {31'd0, run}, 32'd1);
    @(negedge clk);
    chk(!pc_load && pc_addr == 16'h1234, "R11 single pulse, addr held",
        {15'd0, pc_load, pc_addr}, 32'h1234);

    // secondary address ABCD, jump with bank change to 3
    cwr(2'd0, 8'hCD);
    cwr(2'd1, 8'hAB);
    expect_load(16'hABCD, 3'd3, "R8 sec go with bank");
    cwr(2'd2, 8'h0B);
    chk(exec_bank == 3'd3, "R8 bank switched", {29'd0, exec_bank}, 32'd3);

    expect_load(16'h1234, 3'd3, "R9 restart in current bank");
    pulse_end();

    expect_load(16'hABCD, 3'd3, "R7 sec go without bank");
    cwr(2'd2, 8'h06);

    // R10 all triggers at once: primary go wins
    expect_load(16'h1234, 3'd3, "R10 primary go wins");
    @(negedge clk);
    host_wr = 1; host_sel = 2'd3; frame_start = 1; list_end = 1;
    cop_wr = 1; cop_sel = 2'd2; cop_wdata = 8'h0C;
    @(negedge clk);
    host_wr = 0; frame_start = 0; list_end = 0; cop_wr = 0;
    chk(exec_bank == 3'd3, "R10 losing sec go keeps bank", {29'd0, exec_bank}, 32'd3);

    // R3 stop at once, bank 1
    hwr(2'd0, 8'h01);
    chk(!run, "R3 stopped", {31'd0, run}, 32'd0);
    chk(exec_bank == 3'd1, "R5 copy on stop", {29'd0, exec_bank}, 32'd1);

    // R6 coprocessor writes while stopped ignored
    cwr(2'd0, 8'h00);
    cwr(2'd2, 8'h0F);
    pulse_end();
    pulse_frame();
    chk(!run && exec_bank == 3'd1, "R6 ignored while stopped",
        {28'd0, run, exec_bank}, 32'd1);

    // R4 primary go with enable off
    expect_load(16'h1234, 3'd1, "R4 primary go");
    hwr(2'd3, 8'h00);
    chk(run, "R4 running", {31'd0, run}, 32'd1);
    pulse_frame();
    expect_load(16'h1234, 3'd1, "R9 restart");
    pulse_end();
    expect_load(16'hABCD, 3'd1, "R6 sec addr unchanged");
    cwr(2'd2, 8'h00);

    // R10 stop beats secondary go
    @(negedge clk);
    host_wr = 1; host_sel = 2'd0; host_wdata = 8'h02;
    cop_wr = 1; cop_sel = 2'd2; cop_wdata = 8'h0D;
    @(negedge clk);
    host_wr = 0; cop_wr = 0;
    chk(!run && exec_bank == 3'd2, "R10 stop wins", {28'd0, run, exec_bank}, 32'd2);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R11 all loads seen", expq.size(), 32'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule